// File: doc/BRIEF.md
# Dual-Sided Doorbell Interrupt Register

This block holds a 32-bit doorbell word shared by two bus agents. A local host, on its own simple register port, rings the doorbell by writing ones into chosen bits. A remote device, on a second register port, reads the word to learn which doorbells are pending. It then acknowledges them by writing ones to the bits it has serviced. While any bit is pending and the doorbell interrupt enable is high, the block drives an active-low interrupt toward the remote device.

The two ports act on the same bits in opposite ways. The local side can only set bits and the remote side can only clear them. If both act on one bit in the same cycle, the set wins, so a fresh doorbell is never lost to an acknowledge of an older one. A test-mode input turns the local port into a plain read/write port that loads the whole word. Each port has a write strobe with write data and a read strobe with read data. A strobe acts as the register select for the single word that the block implements; in the controller's register map that word sits at word offset 0x3C.

Top module: `doorbell_reg`

## Requirements
- R1: After reset the doorbell word is all zeros, both read-data outputs are zero and the interrupt output `irqN` is high (inactive).
- R2: With `testMode` = 0, a local write sets every doorbell bit whose write-data bit is 1 and leaves the bits written as 0 unchanged.
- R3: A remote write clears every doorbell bit whose write-data bit is 1 and leaves the bits written as 0 unchanged.
- R4: `irqN` is active low. It is driven low on the clock edge after a cycle in which `irqEnable` is 1 and at least one doorbell bit is 1.
- R5: When a local write (`testMode` = 0) and a remote write occur in the same cycle, a bit written 1 by both sides ends up 1. A bit written 1 only by the remote side ends up 0.
- R6: With `testMode` = 1, a local write loads all 32 bits with the write data. This load takes priority over a remote write in the same cycle.
- R7: On each edge where a read strobe is high, that port's read data captures the doorbell word as it stood before that edge's writes. Without the strobe, the read data holds its value.
- R8: `irqN` returns high on the clock edge after a cycle in which the word is all zeros or `irqEnable` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| locWrEn | input | 1 | Local host write strobe |
| locWrData | input | 32 | Local host write data |
| locRdEn | input | 1 | Local host read strobe |
| locRdData | output | 32 | Local host read data |
| remWrEn | input | 1 | Remote device write strobe |
| remWrData | input | 32 | Remote device write data |
| remRdEn | input | 1 | Remote device read strobe |
| remRdData | output | 32 | Remote device read data |
| irqEnable | input | 1 | Doorbell interrupt enable |
| testMode | input | 1 | Turns local writes into full-word loads |
| irqN | output | 1 | Active-low interrupt toward the remote device |

## Verification
The bench builds the block at its default 32-bit width, so every bit position is exercised, including bit 31 and full-word patterns. It runs directed sequences for set, clear, colliding writes, test-mode loads and enable toggling. A long stretch of pseudo-random traffic then drives both ports, the enable and the test mode at once. This traffic reaches same-cycle collisions and clears of the last pending bit that the directed sequences only touch in a few cases.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;

  // Strobes issued by the control module to the datapath each cycle.
  typedef struct packed {
    logic loadAll;  // full-word load from the local side (test mode)
    logic setBits;  // write-1-to-set from the local side
    logic clrBits;  // write-1-to-clear from the remote side
    logic capLoc;   // capture word into local read data
    logic capRem;   // capture word into remote read data
  } dbStrobes_t;

endpackage

// File: rtl/doorbell_ctrl.sv
module doorbell_ctrl
  import doorbell_pkg::*;
(
  input  logic       locWrEn,
  input  logic       locRdEn,
  input  logic       remWrEn,
  input  logic       remRdEn,
  input  logic       testMode,
  output dbStrobes_t strb
);

  always_comb begin
    strb         = '0;
    strb.loadAll = locWrEn & testMode;
    strb.setBits = locWrEn & ~testMode;
    // A test-mode load overrides any remote clear in the same cycle.
    strb.clrBits = remWrEn & ~(locWrEn & testMode);
    strb.capLoc  = locRdEn;
    strb.capRem  = remRdEn;
  end

endmodule

// File: rtl/doorbell_dp.sv
module doorbell_dp
  import doorbell_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dbStrobes_t        strb,
  input  logic [DATA_W-1:0] locWrData,
  input  logic [DATA_W-1:0] remWrData,
  input  logic              irqEnable,
  output logic [DATA_W-1:0] locRdData,
  output logic [DATA_W-1:0] remRdData,
  output logic              irqN
);

  logic [DATA_W-1:0] bellQ;
  logic [DATA_W-1:0] bellNext;

  // Per-bit next state: load beats set, set beats clear.
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    always_comb begin
      if (strb.loadAll)
        bellNext[i] = locWrData[i];
      else if (strb.setBits && locWrData[i])
        bellNext[i] = 1'b1;
      else if (strb.clrBits && remWrData[i])
        bellNext[i] = 1'b0;
      else
        bellNext[i] = bellQ[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bellQ     <= '0;
      locRdData <= '0;
      remRdData <= '0;
      irqN      <= 1'b1;
    end else begin
      bellQ <= bellNext;
      if (strb.capLoc) locRdData <= bellQ;
      if (strb.capRem) remRdData <= bellQ;
      irqN <= ~(irqEnable & (|bellQ));
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strb.setBits |=> ((bellQ & $past(locWrData)) == $past(locWrData))); // R5

  AST_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrBits && !strb.setBits) |=> ((bellQ & $past(remWrData)) == '0)); // R3

  AST_TEST_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadAll |=> (bellQ == $past(locWrData))); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.loadAll || strb.setBits || strb.clrBits) |=> $stable(bellQ)); // R2

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqN == !($past(irqEnable) && ($past(bellQ) != '0)))); // R4

  AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strb.capRem |=> (remRdData == $past(bellQ))); // R7

endmodule

// File: rtl/doorbell_reg.sv
module doorbell_reg
  import doorbell_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              locWrEn,
  input  logic [DATA_W-1:0] locWrData,
  input  logic              locRdEn,
  output logic [DATA_W-1:0] locRdData,
  input  logic              remWrEn,
  input  logic [DATA_W-1:0] remWrData,
  input  logic              remRdEn,
  output logic [DATA_W-1:0] remRdData,
  input  logic              irqEnable,
  input  logic              testMode,
  output logic              irqN
);

  dbStrobes_t strb;

  doorbell_ctrl u_ctrl (
    .locWrEn (locWrEn),
    .locRdEn (locRdEn),
    .remWrEn (remWrEn),
    .remRdEn (remRdEn),
    .testMode(testMode),
    .strb    (strb)
  );

  doorbell_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .locWrData(locWrData),
    .remWrData(remWrData),
    .irqEnable(irqEnable),
    .locRdData(locRdData),
    .remRdData(remRdData),
    .irqN     (irqN)
  );

endmodule

// File: tb/doorbell_reg_tb_top.sv
module doorbell_reg_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        locWrEn = 1'b0, locRdEn = 1'b0, remWrEn = 1'b0, remRdEn = 1'b0;
  logic [31:0] locWrData = '0, remWrData = '0;
  logic        irqEnable = 1'b0, testMode = 1'b0;
  logic [31:0] locRdData, remRdData;
  logic        irqN;

  int    errors = 0;
  int    checks = 0;
  string curReq = "R1";
  bit    done = 1'b0;

  // Reference model state
  logic [31:0] mBell = '0, mLoc = '0, mRem = '0;
  logic        mIrqN = 1'b1;

  always #5 clk = ~clk;

  doorbell_reg dut_i (
    .clk(clk), .rstN(rstN),
    .locWrEn(locWrEn), .locWrData(locWrData), .locRdEn(locRdEn), .locRdData(locRdData),
    .remWrEn(remWrEn), .remWrData(remWrData), .remRdEn(remRdEn), .remRdData(remRdData),
    .irqEnable(irqEnable), .testMode(testMode), .irqN(irqN)
  );

  // Behavioural model, advanced on every rising edge.
  always @(posedge clk) begin
    if (!rstN) begin
      mBell = '0; mLoc = '0; mRem = '0; mIrqN = 1'b1;
    end else begin
      logic [31:0] pre;
      pre = mBell;
      if (locRdEn) mLoc = pre;
      if (remRdEn) mRem = pre;
      mIrqN = !(irqEnable && pre != 0);
      if (locWrEn && testMode) begin
        mBell = locWrData;
      end else begin
        if (remWrEn) mBell = mBell & ~remWrData;
        if (locWrEn) mBell = mBell | locWrData;
      end
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", curReq, what, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("locRdData", locRdData, mLoc);
    chk("remRdData", remRdData, mRem);
    chk("irqN", {31'd0, irqN}, {31'd0, mIrqN});
  endtask

  // One cycle: compare at the falling edge, then drive new inputs.
  task automatic step(input logic lw, input logic [31:0] ld, input logic rw,
                      input logic [31:0] rd, input logic lr, input logic rr,
                      input logic en, input logic tm);
    @(negedge clk);
    compareAll();
    locWrEn = lw; locWrData = ld; remWrEn = rw; remWrData = rd;
    locRdEn = lr; remRdEn = rr; irqEnable = en; testMode = tm;
  endtask

  // Read the word back on both ports and compare against a value the
  // requirement itself predicts.
  task automatic readBoth(input logic [31:0] expWord, input logic en);
    step(0, '0, 0, '0, 1, 1, en, 0);
    step(0, '0, 0, '0, 0, 0, en, 0);
    chk("locRdData direct", locRdData, expWord);
    chk("remRdData direct", remRdData, expWord);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin : stimulus
    logic [31:0] lfsr;
    lfsr = 32'hACE1_1234;
    repeat (3) @(negedge clk);
    curReq = "R1";
    chk("reset locRdData", locRdData, '0);
    chk("reset remRdData", remRdData, '0);
    chk("reset irqN", {31'd0, irqN}, 32'd1);
    rstN = 1'b1;
    readBoth(32'h0, 0);

    curReq = "R2";
    step(1, 32'h0000_00F1, 0, '0, 0, 0, 0, 0);
    step(1, 32'h8000_0100, 0, '0, 0, 0, 0, 0);
    step(1, 32'h0000_0000, 0, '0, 0, 0, 0, 0);
    readBoth(32'h8000_01F1, 0);

    curReq = "R3";
    step(0, '0, 1, 32'h0000_0031, 0, 0, 0, 0);
    step(0, '0, 1, 32'h0000_0000, 0, 0, 0, 0);
    readBoth(32'h8000_01C0, 0);

    curReq = "R4";
    step(0, '0, 0, '0, 0, 0, 1, 0);
    step(0, '0, 0, '0, 0, 0, 1, 0);
    step(0, '0, 0, '0, 0, 0, 1, 0);
    chk("irqN low when pending and enabled", {31'd0, irqN}, 32'd0);

    curReq = "R8";
    step(0, '0, 0, '0, 0, 0, 0, 0);
    step(0, '0, 0, '0, 0, 0, 1, 0);
    chk("irqN high after enable dropped", {31'd0, irqN}, 32'd1);
    step(0, '0, 1, 32'h8000_01C0, 0, 0, 1, 0);
    step(0, '0, 0, '0, 0, 0, 1, 0);
    step(0, '0, 0, '0, 0, 0, 1, 0);
    chk("irqN high after last bit cleared", {31'd0, irqN}, 32'd1);

    curReq = "R5";
    step(1, 32'h0000_FFFF, 0, '0, 0, 0, 1, 0);
    step(1, 32'h0000_000F, 1, 32'h0000_00FF, 0, 0, 1, 0);
    readBoth(32'h0000_FF0F, 1);

    curReq = "R6";
    step(1, 32'h1234_5670, 1, 32'hFFFF_FFFF, 0, 0, 1, 1);
    readBoth(32'h1234_5670, 1);
    step(1, 32'h0000_0000, 0, '0, 0, 0, 1, 1);
    readBoth(32'h0000_0000, 1);

    curReq = "R7";
    step(1, 32'hDEAD_0001, 0, '0, 1, 0, 1, 0);
    step(0, '0, 0, '0, 0, 0, 1, 0);
    chk("local read captured pre-write word", locRdData, 32'h0000_0000);
    step(0, '0, 0, '0, 0, 1, 1, 0);
    step(0, '0, 0, '0, 0, 0, 1, 0);
    chk("remote read sees word", remRdData, 32'hDEAD_0001);
    chk("local read held", locRdData, 32'h0000_0000);

    curReq = "R5";
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr & {lfsr[7:0], lfsr[31:8]};
      b = lfsr ^ {lfsr[15:0], lfsr[31:16]};
      step(lfsr[3], a, lfsr[5], b, lfsr[9], lfsr[12], lfsr[14] | lfsr[2],
           lfsr[20] & lfsr[25] & lfsr[6]);
    end
    step(0, '0, 0, '0, 0, 0, 0, 0);
    step(0, '0, 0, '0, 0, 0, 0, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule